// File: doc/BRIEF.md
# Serial Clock Line Reset Pattern Detector

This block watches a serial clock line that is normally driven by a host for data transfers. It samples the line with the system clock and looks for a special waveform that the host can send to force a reset of a slave interface without a dedicated reset wire. The waveform consists of three high pulses separated by low gaps. Each high pulse must have a length inside its own window, counted in system clock periods. When the third pulse ends inside its window, the block emits a one-cycle reset request. The serial port and the register bank use this request.

The line passes through a synchroniser first. A run-length counter then measures every high and every low stretch. A small sequencer compares each finished stretch against the windows. Any stretch outside its window abandons the partial match. A high pulse that fails its own window but fits the first window starts a new match at once. All window limits are parameters.

Top module: `sclk_reset_detect`

## Requirements
- R1: A high pulse is accepted as the first pulse of the pattern only if it lasts more than 512 and fewer than 800 system clock periods. Lengths of 512 and 800 are rejected.
- R2: Each low gap after an accepted pulse must last more than 10 system clock periods. A gap of 10 or fewer abandons the match.
- R3: The second high pulse must last more than 1024 and fewer than 1800 system clock periods.
- R4: The third high pulse must last at least 2048 and fewer than 2400 system clock periods.
- R5: The reset request is raised by the falling edge that ends a valid third pulse. It appears `SYNC_STAGES`+1 clock edges after the first system clock edge that samples the line low.
- R6: A second or third pulse that fails its own window abandons the match. If that same pulse fits the first window, it is taken as the first pulse of a new match.
- R7: Stretch lengths saturate. A line held high for a very long time never matches any window, whatever its length.
- R8: `reset_pulse` is high for exactly one system clock cycle. The detector re-arms in the same cycle, so a following pattern is recognised after an ordinary gap.
- R9: After `rst_n` is released, `reset_pulse` is low and the detector is waiting for a first pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for sampling and counting |
| rst_n | input | 1 | Asynchronous active-low reset |
| serial_clk | input | 1 | Serial clock line, asynchronous to `clk` |
| reset_pulse | output | 1 | One-cycle reset request for the serial port and register bank |

## Verification
Two decisions can land on one falling edge. The first is rejecting the pulse under test. The second is accepting that same pulse as the first pulse of a new match. The bench provokes this by sending a 600-cycle pulse where the second pulse is expected, then a normal second and third pulse. It judges the result by requiring `reset_pulse` in exactly the cycle predicted from the final falling edge.

A similar overlap occurs when the detector fires and re-arms in one cycle. The bench sends two complete patterns back to back, separated by a short legal gap, and expects both requests.

// File: rtl/rdet_pkg.sv
package rdet_pkg;

   // Progress through the three-pulse pattern
   typedef enum logic [1:0] {
      PH_HUNT = 2'd0,
      PH_ONE  = 2'd1,
      PH_TWO  = 2'd2
   } phase_t;

endpackage

// File: rtl/rdet_sync.sv
module rdet_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("rdet_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= 1'b0;
            else        ff <= d_async;
         end
         assign q_sync = ff;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-2:0], d_async};
         end
         assign q_sync = sh[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rdet_runlen.sv
module rdet_runlen #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_s,
   output logic             fall_evt,
   output logic             rise_evt,
   output logic [CNT_W-1:0] run_len
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic line_q;

   // run_len = cycles the level in line_q has been held so far
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q  <= 1'b0;
         run_len <= '0;
      end else begin
         line_q <= line_s;
         if (line_s != line_q)      run_len <= CNT_ONE;
         else if (run_len != CNT_MAX) run_len <= run_len + 1'b1;
      end
   end

   assign fall_evt = line_q & ~line_s;
   assign rise_evt = ~line_q & line_s;

endmodule

// File: rtl/rdet_seq.sv
module rdet_seq
   import rdet_pkg::*;
#(
   parameter int CNT_W       = 12,
   parameter int HI1_ABOVE   = 512,
   parameter int HI1_BELOW   = 800,
   parameter int GAP_ABOVE   = 10,
   parameter int HI2_ABOVE   = 1024,
   parameter int HI2_BELOW   = 1800,
   parameter int HI3_ATLEAST = 2048,
   parameter int HI3_BELOW   = 2400
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fall_evt,
   input  logic             rise_evt,
   input  logic [CNT_W-1:0] run_len,
   output phase_t           phase,
   output logic             fire
);

   localparam logic [CNT_W-1:0] L1_LO = CNT_W'(HI1_ABOVE);
   localparam logic [CNT_W-1:0] L1_HI = CNT_W'(HI1_BELOW);
   localparam logic [CNT_W-1:0] LG_LO = CNT_W'(GAP_ABOVE);
   localparam logic [CNT_W-1:0] L2_LO = CNT_W'(HI2_ABOVE);
   localparam logic [CNT_W-1:0] L2_HI = CNT_W'(HI2_BELOW);
   localparam logic [CNT_W-1:0] L3_LO = CNT_W'(HI3_ATLEAST);
   localparam logic [CNT_W-1:0] L3_HI = CNT_W'(HI3_BELOW);

   logic   in_w1, in_w2, in_w3, gap_ok;
   phase_t phase_nxt;
   logic   fire_nxt;

   assign in_w1  = (run_len >  L1_LO) && (run_len < L1_HI);
   assign in_w2  = (run_len >  L2_LO) && (run_len < L2_HI);
   assign in_w3  = (run_len >= L3_LO) && (run_len < L3_HI);
   assign gap_ok = (run_len >  LG_LO);

   always_comb begin
      phase_nxt = phase;
      fire_nxt  = 1'b0;
      if (fall_evt) begin
         if (phase == PH_TWO && in_w3) begin
            fire_nxt  = 1'b1;
            phase_nxt = PH_HUNT;
         end else if (phase == PH_ONE && in_w2) begin
            phase_nxt = PH_TWO;
         end else if (in_w1) begin
            phase_nxt = PH_ONE;
         end else begin
            phase_nxt = PH_HUNT;
         end
      end else if (rise_evt && phase != PH_HUNT && !gap_ok) begin
         phase_nxt = PH_HUNT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_HUNT;
         fire  <= 1'b0;
      end else begin
         phase <= phase_nxt;
         fire  <= fire_nxt;
      end
   end

endmodule

// File: rtl/sclk_reset_detect.sv
module sclk_reset_detect
   import rdet_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int HI1_ABOVE   = 512,
   parameter int HI1_BELOW   = 800,
   parameter int GAP_ABOVE   = 10,
   parameter int HI2_ABOVE   = 1024,
   parameter int HI2_BELOW   = 1800,
   parameter int HI3_ATLEAST = 2048,
   parameter int HI3_BELOW   = 2400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic serial_clk,
   output logic reset_pulse
);

   // one spare code above the last limit so that saturation matches no window
   localparam int CNT_W = $clog2(HI3_BELOW + 1);

   generate
      if (HI1_BELOW <= HI1_ABOVE + 1) begin : g_bad_w1
         $error("first window is empty");
      end
      if (HI2_BELOW <= HI2_ABOVE + 1) begin : g_bad_w2
         $error("second window is empty");
      end
      if (HI3_BELOW <= HI3_ATLEAST) begin : g_bad_w3
         $error("third window is empty");
      end
      if (HI1_BELOW > HI2_ABOVE + 1 || HI2_BELOW > HI3_ATLEAST) begin : g_bad_order
         $error("windows must be disjoint and ascending");
      end
      if (GAP_ABOVE < 1 || GAP_ABOVE >= HI3_BELOW) begin : g_bad_gap
         $error("gap limit out of range");
      end
   endgenerate

   logic             line_s;
   logic             fall_evt;
   logic             rise_evt;
   logic [CNT_W-1:0] run_len;
   phase_t           phase;

   rdet_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (serial_clk),
      .q_sync  (line_s)
   );

   rdet_runlen #(.CNT_W(CNT_W)) u_runlen (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_s   (line_s),
      .fall_evt (fall_evt),
      .rise_evt (rise_evt),
      .run_len  (run_len)
   );

   rdet_seq #(
      .CNT_W       (CNT_W),
      .HI1_ABOVE   (HI1_ABOVE),
      .HI1_BELOW   (HI1_BELOW),
      .GAP_ABOVE   (GAP_ABOVE),
      .HI2_ABOVE   (HI2_ABOVE),
      .HI2_BELOW   (HI2_BELOW),
      .HI3_ATLEAST (HI3_ATLEAST),
      .HI3_BELOW   (HI3_BELOW)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .fall_evt (fall_evt),
      .rise_evt (rise_evt),
      .run_len  (run_len),
      .phase    (phase),
      .fire     (reset_pulse)
   );

endmodule

// File: rtl/sclk_reset_detect_chk.sv
module sclk_reset_detect_chk
   import rdet_pkg::*;
#(
   parameter int CNT_W     = 12,
   parameter int HI1_ABOVE = 512,
   parameter int HI1_BELOW = 800,
   parameter int GAP_ABOVE = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reset_pulse,
   input logic             fall_evt,
   input logic             rise_evt,
   input logic [CNT_W-1:0] run_len,
   input phase_t           phase
);

   localparam logic [CNT_W-1:0] C1_LO  = CNT_W'(HI1_ABOVE);
   localparam logic [CNT_W-1:0] C1_HI  = CNT_W'(HI1_BELOW);
   localparam logic [CNT_W-1:0] CG_LIM = CNT_W'(GAP_ABOVE);
   localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);

   // R8
   single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reset_pulse |=> !reset_pulse);

   // R8
   rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reset_pulse |-> phase == PH_HUNT);

   // R5
   fire_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reset_pulse |-> $past(fall_evt));

   // R7
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_len != C_ONE) |-> run_len >= $past(run_len));

   // R6
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_evt && run_len > C1_LO && run_len < C1_HI) |=> phase == PH_ONE);

   // R2
   short_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_evt && run_len <= CG_LIM) |=> phase == PH_HUNT);

endmodule

bind sclk_reset_detect sclk_reset_detect_chk #(
   .CNT_W     (CNT_W),
   .HI1_ABOVE (HI1_ABOVE),
   .HI1_BELOW (HI1_BELOW),
   .GAP_ABOVE (GAP_ABOVE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reset_pulse (reset_pulse),
   .fall_evt    (fall_evt),
   .rise_evt    (rise_evt),
   .run_len     (run_len),
   .phase       (phase)
);

// File: tb/sclk_reset_detect_bench.sv
`timescale 1ns/1ps
module sclk_reset_detect_bench;

   localparam int LAT = 3; // two synchroniser flops + registered output

   typedef struct {
      int    cyc;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic serial_clk = 1'b0;
   logic reset_pulse;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   int seen = 0;
   int want = 0;
   bit done = 1'b0;
   exp_t sb[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sclk_reset_detect u_sclk_reset_detect (
      .clk         (clk),
      .rst_n       (rst_n),
      .serial_clk  (serial_clk),
      .reset_pulse (reset_pulse)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit exp_now;
         if (sb.size() > 0 && sb[0].cyc < cyc) begin
            check(1'b0, {sb[0].tag, " missing pulse"}, 0, 1);
            void'(sb.pop_front());
         end
         exp_now = (sb.size() > 0 && sb[0].cyc == cyc);
         if (reset_pulse || exp_now) begin
            check(reset_pulse && exp_now,
                  exp_now ? sb[0].tag : "R8 unexpected pulse",
                  int'(reset_pulse), int'(exp_now));
            if (exp_now) void'(sb.pop_front());
         end
         if (reset_pulse) seen++;
      end
   end

   task automatic hold(input bit lv, input int n);
      serial_clk = lv;
      repeat (n) @(negedge clk);
   endtask

   task automatic pattern(input int p1, input int g1, input int p2, input int g2,
                          input int p3, input bit fire, input string tag);
      exp_t e;
      hold(1'b1, p1);
      hold(1'b0, g1);
      hold(1'b1, p2);
      hold(1'b0, g2);
      hold(1'b1, p3);
      if (fire) begin
         e.cyc = cyc + LAT;
         e.tag = tag;
         sb.push_back(e);
         want++;
      end
      hold(1'b0, 30);
      check(seen == want, {tag, " pulse count"}, seen, want);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      check(reset_pulse == 1'b0, "R9 idle after reset", int'(reset_pulse), 0);
      hold(1'b0, 20);
      check(reset_pulse == 1'b0, "R9 quiet line", int'(reset_pulse), 0);

      pattern(600, 20, 1400, 20, 2200, 1'b1, "R5 nominal");
      pattern(513, 11, 1025, 11, 2048, 1'b1, "R1 R3 R4 lower edges");
      pattern(799, 11, 1799, 11, 2399, 1'b1, "R1 R3 R4 upper edges");
      pattern(512, 20, 1400, 20, 2200, 1'b0, "R1 first too short");
      pattern(800, 20, 1400, 20, 2200, 1'b0, "R1 first too long");
      pattern(600, 10, 1400, 20, 2200, 1'b0, "R2 first gap 10");
      pattern(600, 20, 1400, 10, 2200, 1'b0, "R2 second gap 10");
      pattern(600, 20, 1024, 20, 2200, 1'b0, "R3 second too short");
      pattern(600, 20, 1800, 20, 2200, 1'b0, "R3 second too long");
      pattern(600, 20, 1400, 20, 2047, 1'b0, "R4 third too short");
      pattern(600, 20, 1400, 20, 2400, 1'b0, "R4 third too long");

      // R6: a bad second pulse of 600 becomes a new first pulse
      hold(1'b1, 600);
      hold(1'b0, 20);
      pattern(600, 20, 1400, 20, 2200, 1'b1, "R6 restart on second");
      // R6: a bad third pulse of 700 becomes a new first pulse
      hold(1'b1, 600);
      hold(1'b0, 20);
      hold(1'b1, 1400);
      hold(1'b0, 20);
      pattern(700, 20, 1400, 20, 2200, 1'b1, "R6 restart on third");

      // R7: 4096 + 2200 would alias into the third window without saturation
      pattern(600, 20, 1400, 20, 6296, 1'b0, "R7 long third");
      hold(1'b1, 6296);
      hold(1'b0, 20);
      check(seen == want, "R7 long high alone", seen, want);

      // R8: two patterns back to back, short legal gap
      pattern(600, 11, 1400, 11, 2200, 1'b1, "R8 first of pair");
      pattern(600, 12, 1400, 12, 2200, 1'b1, "R8 second of pair");

      check(sb.size() == 0, "R5 scoreboard drained", sb.size(), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(190000 * 5);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=0", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule